// File: doc/BRIEF.md
# Double-Buffered Window Configuration Registers with Frame-Boundary Commit

This block holds the configuration of a small set of display windows in two copies. Software writes the working copy through a simple register write port. The scanout logic only ever sees the shadow copy. Values move from the working copy to the shadow copy only when a frame-boundary strobe (`vsync`) arrives. This means a group of related fields never reaches the scanout half-written.

Each window carries four fields: an enable flag, a buffer base address, and a top-left X and Y position. To commit, software writes a request bit. The request marks every window as pending, and each pending window is copied at the next frame boundary. Each window also has its own protect bit. While that bit is set, the window is skipped at the frame boundary, but its pending mark is kept. Software can therefore freeze a window, rewrite several fields, release it, and have the whole set land together at the next frame. A one-cycle completion pulse reports every frame boundary at which at least one window was copied. Both copies can be read back.

Top module: `shadow_regs`

## Requirements
- R1: The shadow outputs (`shadowEn`, `shadowBase`, `shadowX`, `shadowY`) change only on a clock edge where `vsync` is high. A register write alone never alters them.
- R2: Address map: `wrAddr[3:2]` selects a window (0 or 1) or the global page (2). `wrAddr[1:0]` selects a field:
  - field 0 is the enable, in bit 0;
  - field 1 is the base address, 32 bits;
  - field 2 is the position, with X in bits 11:0 and Y in bits 27:16;
  - field 3 is reserved. It reads 0 and writes to it are ignored.
  
  Writes reach the working copy one cycle later. A read with `rdShadow`=0 returns the working copy and a read with `rdShadow`=1 returns the shadow copy, with the same layout.
- R3: Writing 1 to bit 0 of global field 1 marks every window pending. At the next `vsync` edge, each pending window whose protect bit is clear copies all four working fields into its shadow copy together, and its pending mark is cleared.
- R4: Global field 0, bits 1:0, holds the per-window protect mask. A protected window keeps its shadow copy at a `vsync` edge and keeps its pending mark.
- R5: After a pending window is unprotected, the next `vsync` edge copies it without a new commit request.
- R6: A `vsync` edge with no window pending copies nothing, so uncommitted writes stay out of the shadow copy.
- R7: Clearing a window's enable in the working copy leaves `shadowEn` for that window at 1 until the committing `vsync` edge.
- R8: `commitDone` is high for exactly the one cycle after a `vsync` edge at which at least one window was copied, and low otherwise.
- R9: Reading global field 1 returns, in bit 0, whether any window is still pending. A commit request given in the same cycle as `vsync` is kept for the following `vsync` edge.
- R10: After reset:
  - all working and shadow fields are 0;
  - the protect mask is 0;
  - no window is pending;
  - `commitDone` is 0.
- R11: A field write in the same cycle as a committing `vsync` updates only the working copy. The shadow copy takes the value held before that edge.
- R12: A protect-mask write in the same cycle as `vsync` takes effect only from the following edge. The mask held before the edge decides that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address (page in 3:2, field in 1:0) |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Read address, same layout as wrAddr |
| rdShadow | input | 1 | 1 selects the shadow copy on window reads |
| rdData | output | 32 | Combinational read data |
| vsync | input | 1 | One-cycle frame-boundary strobe |
| shadowEn | output | 2 | Shadow enable per window |
| shadowBase | output | 64 | Shadow base address, window w at [32w+31:32w] |
| shadowX | output | 24 | Shadow X, window w at [12w+11:12w] |
| shadowY | output | 24 | Shadow Y, window w at [12w+11:12w] |
| commitDone | output | 1 | Pulse after a frame boundary that copied a window |

## Verification
The working copy, the protect mask and the pending marks all change one clock edge after the write that targets them. Readback is combinational from those registers. The shadow outputs and `commitDone` change at the `vsync` edge itself and are due one cycle after `vsync` is driven. The bench drives every input on the falling edge and updates its reference model at the rising edge from the values seen there. It then compares all shadow outputs and `commitDone` on the next falling edge, and makes readback comparisons a short delay after a falling edge. The directed cases put writes, protect changes and commit requests in the very cycle of `vsync`, so that the before-edge rule is tested exactly.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  localparam int unsigned FLD_W = 2;
  localparam int unsigned Y_LSB = 16;

  typedef enum logic [FLD_W-1:0] {
    FLD_CTL  = 2'd0,
    FLD_BASE = 2'd1,
    FLD_POS  = 2'd2,
    FLD_RSVD = 2'd3
  } field_e;

  typedef enum logic [FLD_W-1:0] {
    GLB_PROT = 2'd0,
    GLB_UPD  = 2'd1,
    GLB_R2   = 2'd2,
    GLB_R3   = 2'd3
  } glb_e;

  // per-window strobes from control to datapath
  typedef struct packed {
    logic wrCtl;
    logic wrBase;
    logic wrPos;
    logic load;
  } win_strobe_t;

endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_pkg::*;
#(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_AW  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_AW-1:0]    wrAddr,
  input  logic [NUM_WIN-1:0]   wrBits,
  input  logic                 vsync,
  input  logic [REG_AW-1:0]    rdAddr,
  output win_strobe_t          strobe [NUM_WIN],
  output logic                 commitDone,
  output logic                 rdIsGlobal,
  output logic [DATA_W-1:0]    rdGlobal
);

  localparam int unsigned WIN_IDX_W = REG_AW - FLD_W;

  logic [WIN_IDX_W-1:0] wrWin, rdWin;
  logic [FLD_W-1:0]     wrFld, rdFld;
  logic                 glbWr, protWr, updReq;
  logic [NUM_WIN-1:0]   protMask, pend, loadVec;

  assign wrWin  = wrAddr[REG_AW-1:FLD_W];
  assign wrFld  = wrAddr[FLD_W-1:0];
  assign rdWin  = rdAddr[REG_AW-1:FLD_W];
  assign rdFld  = rdAddr[FLD_W-1:0];

  assign glbWr  = wrEn && (wrWin == WIN_IDX_W'(NUM_WIN));
  assign protWr = glbWr && (wrFld == GLB_PROT);
  assign updReq = glbWr && (wrFld == GLB_UPD) && wrBits[0];

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : gWin
      logic hit;
      assign hit        = wrEn && (wrWin == WIN_IDX_W'(w));
      assign loadVec[w] = vsync && pend[w] && !protMask[w];
      assign strobe[w]  = '{wrCtl:  hit && (wrFld == FLD_CTL),
                            wrBase: hit && (wrFld == FLD_BASE),
                            wrPos:  hit && (wrFld == FLD_POS),
                            load:   loadVec[w]};

      AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rstN)
        (pend[w] && protMask[w]) |=> pend[w]); // R4
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protMask   <= '0;
      pend       <= '0;
      commitDone <= 1'b0;
    end else begin
      if (protWr) protMask <= wrBits;
      pend       <= (pend & ~loadVec) | {NUM_WIN{updReq}};
      commitDone <= |loadVec;
    end
  end

  assign rdIsGlobal = (rdWin == WIN_IDX_W'(NUM_WIN));

  always_comb begin
    rdGlobal = '0;
    if (rdFld == GLB_PROT)     rdGlobal = DATA_W'(protMask);
    else if (rdFld == GLB_UPD) rdGlobal = DATA_W'(|pend);
  end

  AST_DONE_AT_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> $past(vsync)); // R8
  AST_IDLE_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (vsync && !(|pend)) |=> !commitDone); // R6

endmodule

// File: rtl/shadow_datapath.sv
module shadow_datapath
  import shadow_pkg::*;
#(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BASE_W  = 32,
  parameter int unsigned POS_W   = 12,
  parameter int unsigned REG_AW  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  win_strobe_t               strobe [NUM_WIN],
  input  logic [DATA_W-1:0]         wrData,
  input  logic [REG_AW-1:0]         rdAddr,
  input  logic                      rdShadow,
  output logic [NUM_WIN-1:0]        shadowEn,
  output logic [NUM_WIN*BASE_W-1:0] shadowBase,
  output logic [NUM_WIN*POS_W-1:0]  shadowX,
  output logic [NUM_WIN*POS_W-1:0]  shadowY,
  output logic [DATA_W-1:0]         rdWinData
);

  localparam int unsigned WIN_IDX_W = REG_AW - FLD_W;

  logic              actEn   [NUM_WIN];
  logic [BASE_W-1:0] actBase [NUM_WIN];
  logic [POS_W-1:0]  actX    [NUM_WIN];
  logic [POS_W-1:0]  actY    [NUM_WIN];
  logic              shEn    [NUM_WIN];
  logic [BASE_W-1:0] shBase  [NUM_WIN];
  logic [POS_W-1:0]  shX     [NUM_WIN];
  logic [POS_W-1:0]  shY     [NUM_WIN];

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : gWin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          actEn[w]   <= 1'b0;
          actBase[w] <= '0;
          actX[w]    <= '0;
          actY[w]    <= '0;
        end else begin
          if (strobe[w].wrCtl)  actEn[w]   <= wrData[0];
          if (strobe[w].wrBase) actBase[w] <= wrData[BASE_W-1:0];
          if (strobe[w].wrPos) begin
            actX[w] <= wrData[POS_W-1:0];
            actY[w] <= wrData[Y_LSB +: POS_W];
          end
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shEn[w]   <= 1'b0;
          shBase[w] <= '0;
          shX[w]    <= '0;
          shY[w]    <= '0;
        end else if (strobe[w].load) begin
          shEn[w]   <= actEn[w];
          shBase[w] <= actBase[w];
          shX[w]    <= actX[w];
          shY[w]    <= actY[w];
        end
      end

      assign shadowEn[w]                 = shEn[w];
      assign shadowBase[w*BASE_W +: BASE_W] = shBase[w];
      assign shadowX[w*POS_W +: POS_W]   = shX[w];
      assign shadowY[w*POS_W +: POS_W]   = shY[w];

      AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !strobe[w].load |=> ($stable(shEn[w]) && $stable(shBase[w]) &&
                             $stable(shX[w]) && $stable(shY[w]))); // R1
      AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rstN)
        strobe[w].load |=> (shBase[w] == $past(actBase[w]) &&
                            shEn[w] == $past(actEn[w]))); // R3
      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
        strobe[w].wrBase |=> actBase[w] == $past(wrData[BASE_W-1:0])); // R2
    end
  endgenerate

  logic [WIN_IDX_W-1:0] rdWin;
  logic [FLD_W-1:0]     rdFld;
  assign rdWin = rdAddr[REG_AW-1:FLD_W];
  assign rdFld = rdAddr[FLD_W-1:0];

  always_comb begin
    rdWinData = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (rdWin == WIN_IDX_W'(i)) begin
        case (rdFld)
          FLD_CTL:  rdWinData = DATA_W'(rdShadow ? shEn[i] : actEn[i]);
          FLD_BASE: rdWinData = DATA_W'(rdShadow ? shBase[i] : actBase[i]);
          FLD_POS:  rdWinData = (DATA_W'(rdShadow ? shY[i] : actY[i]) << Y_LSB) |
                                DATA_W'(rdShadow ? shX[i] : actX[i]);
          default:  rdWinData = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/shadow_regs.sv
module shadow_regs
  import shadow_pkg::*;
#(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BASE_W  = 32,
  parameter int unsigned POS_W   = 12,
  localparam int unsigned REG_AW = $clog2(NUM_WIN + 1) + FLD_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [REG_AW-1:0]         wrAddr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [REG_AW-1:0]         rdAddr,
  input  logic                      rdShadow,
  output logic [DATA_W-1:0]         rdData,
  input  logic                      vsync,
  output logic [NUM_WIN-1:0]        shadowEn,
  output logic [NUM_WIN*BASE_W-1:0] shadowBase,
  output logic [NUM_WIN*POS_W-1:0]  shadowX,
  output logic [NUM_WIN*POS_W-1:0]  shadowY,
  output logic                      commitDone
);

  win_strobe_t       strobe [NUM_WIN];
  logic              rdIsGlobal;
  logic [DATA_W-1:0] rdGlobal, rdWinData;

  shadow_ctrl #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .REG_AW(REG_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrBits(wrData[NUM_WIN-1:0]), .vsync(vsync), .rdAddr(rdAddr),
    .strobe(strobe), .commitDone(commitDone),
    .rdIsGlobal(rdIsGlobal), .rdGlobal(rdGlobal)
  );

  shadow_datapath #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .BASE_W(BASE_W),
                    .POS_W(POS_W), .REG_AW(REG_AW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdAddr(rdAddr), .rdShadow(rdShadow),
    .shadowEn(shadowEn), .shadowBase(shadowBase),
    .shadowX(shadowX), .shadowY(shadowY), .rdWinData(rdWinData)
  );

  assign rdData = rdIsGlobal ? rdGlobal : rdWinData;

  AST_EN_WAITS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !vsync |=> $stable(shadowEn)); // R7
  AST_POS_WAITS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !vsync |=> ($stable(shadowX) && $stable(shadowY) && $stable(shadowBase))); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> !commitDone || $past(vsync, 1)); // R8

endmodule

// File: tb/sim_shadow_regs.sv
`timescale 1ns/1ps
module sim_shadow_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic        rdShadow = 1'b0;
  logic [31:0] rdData;
  logic        vsync = 1'b0;
  logic [1:0]  shadowEn;
  logic [63:0] shadowBase;
  logic [23:0] shadowX, shadowY;
  logic        commitDone;

  always #2.5 clk = ~clk;

  shadow_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdShadow(rdShadow), .rdData(rdData), .vsync(vsync),
    .shadowEn(shadowEn), .shadowBase(shadowBase), .shadowX(shadowX),
    .shadowY(shadowY), .commitDone(commitDone)
  );

  int nChk = 0, nBad = 0;
  bit finished = 0;

  // reference model
  bit        mEn[2], sEn[2];
  bit [31:0] mBase[2], sBase[2];
  bit [11:0] mX[2], mY[2], sX[2], sY[2];
  bit [1:0]  mProt, mPend;
  bit        mDone;

  task automatic cmp(string tag, string what, logic [63:0] got, logic [63:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic bit [31:0] expRead(bit [3:0] a, bit sh);
    bit [1:0] win = a[3:2];
    bit [1:0] f = a[1:0];
    if (win < 2) begin
      case (f)
        2'd0: return {31'd0, sh ? sEn[win] : mEn[win]};
        2'd1: return sh ? sBase[win] : mBase[win];
        2'd2: return sh ? {4'd0, sY[win], 4'd0, sX[win]} : {4'd0, mY[win], 4'd0, mX[win]};
        default: return 32'd0;
      endcase
    end else if (win == 2) begin
      if (f == 0) return {30'd0, mProt};
      if (f == 1) return {31'd0, |mPend};
    end
    return 32'd0;
  endfunction

  task automatic modelEdge();
    bit any = 0;
    for (int w = 0; w < 2; w++) begin
      if (vsync && mPend[w] && !mProt[w]) begin
        sEn[w] = mEn[w]; sBase[w] = mBase[w]; sX[w] = mX[w]; sY[w] = mY[w];
        mPend[w] = 1'b0;
        any = 1;
      end
    end
    mDone = any;
    if (wrEn) begin
      if (wrAddr[3:2] < 2) begin
        case (wrAddr[1:0])
          2'd0: mEn[wrAddr[3:2]] = wrData[0];
          2'd1: mBase[wrAddr[3:2]] = wrData;
          2'd2: begin mX[wrAddr[3:2]] = wrData[11:0]; mY[wrAddr[3:2]] = wrData[27:16]; end
          default: ;
        endcase
      end else if (wrAddr[3:2] == 2) begin
        if (wrAddr[1:0] == 0) mProt = wrData[1:0];
        if (wrAddr[1:0] == 1 && wrData[0]) mPend = 2'b11;
      end
    end
  endtask

  task automatic checkOuts(string tag);
    cmp(tag, "shadowEn", 64'(shadowEn), 64'({sEn[1], sEn[0]}));
    cmp(tag, "shadowBase", shadowBase, {sBase[1], sBase[0]});
    cmp(tag, "shadowX", 64'(shadowX), 64'({sX[1], sX[0]}));
    cmp(tag, "shadowY", 64'(shadowY), 64'({sY[1], sY[0]}));
    cmp(tag, "commitDone", 64'(commitDone), 64'(mDone));
  endtask

  // one clock: inputs already driven; model at rising edge, compare at falling
  task automatic tick(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkOuts(tag);
    wrEn = 1'b0; vsync = 1'b0;
  endtask

  task automatic drive(bit we, bit [3:0] a, bit [31:0] d, bit vs);
    wrEn = we; wrAddr = a; wrData = d; vsync = vs;
  endtask

  task automatic wr(string tag, bit [3:0] a, bit [31:0] d);
    drive(1, a, d, 0); tick(tag);
  endtask

  task automatic frame(string tag);
    drive(0, 4'd0, 32'd0, 1); tick(tag);
  endtask

  task automatic readChk(string tag, bit [3:0] a, bit sh);
    rdAddr = a; rdShadow = sh;
    #0.5;
    cmp(tag, "rdData", 64'(rdData), 64'(expRead(a, sh)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R10: reset state
    repeat (3) @(negedge clk);
    checkOuts("R10");
    rstN = 1'b1;
    @(negedge clk);
    checkOuts("R10");
    readChk("R10", 4'h8, 0);
    readChk("R10", 4'h9, 0);
    readChk("R10", 4'h1, 0);

    // R2: writes reach the working copy only
    wr("R2", 4'h1, 32'hA000_1000);
    wr("R2", 4'h2, 32'h0123_0456);
    wr("R2", 4'h0, 32'h1);
    wr("R2", 4'h3, 32'hFFFF_FFFF);
    readChk("R2", 4'h1, 0);
    readChk("R2", 4'h2, 0);
    readChk("R2", 4'h0, 0);
    readChk("R2", 4'h3, 0);
    readChk("R1", 4'h1, 1);
    // R6: frame without request copies nothing
    frame("R6");

    // R3 / R8: commit request then frame
    wr("R3", 4'h9, 32'h1);
    readChk("R9", 4'h9, 0);
    frame("R3");
    drive(0, 0, 0, 0); tick("R8");
    readChk("R3", 4'h2, 1);
    readChk("R9", 4'h9, 0);

    // R4 / R5: protect window 1, update, release
    wr("R4", 4'h8, 32'h2);
    wr("R4", 4'h5, 32'hBEEF_0000);
    wr("R4", 4'h4, 32'h1);
    wr("R4", 4'h9, 32'h1);
    frame("R4");
    readChk("R4", 4'h9, 0);
    frame("R4");
    wr("R5", 4'h8, 32'h0);
    frame("R5");
    readChk("R5", 4'h5, 1);

    // R7: disable waits for the frame
    wr("R7", 4'h0, 32'h0);
    wr("R7", 4'h9, 32'h1);
    repeat (4) begin drive(0, 0, 0, 0); tick("R7"); end
    frame("R7");

    // R11: write in the committing cycle
    wr("R11", 4'h9, 32'h1);
    drive(1, 4'h1, 32'h5555_AAAA, 1); tick("R11");
    readChk("R11", 4'h1, 1);
    readChk("R11", 4'h1, 0);

    // R12: protect write in the frame cycle
    wr("R12", 4'h9, 32'h1);
    drive(1, 4'h8, 32'h3, 1); tick("R12");
    wr("R12", 4'h9, 32'h1);
    drive(1, 4'h8, 32'h0, 1); tick("R12");
    frame("R12");

    // R9: request coinciding with a frame is kept
    drive(1, 4'h9, 32'h1, 1); tick("R9");
    readChk("R9", 4'h9, 0);
    wr("R9", 4'h6, 32'h0777_0888);
    frame("R9");
    readChk("R9", 4'h9, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      bit [3:0] a;
      bit [31:0] d = $urandom;
      bit vs = ($urandom % 6) == 0;
      if (r < 7) begin
        a = {2'($urandom % 2), 2'($urandom)};
        drive(1, a, d, vs);
      end else if (r < 9) drive(1, 4'h8, d, vs);
      else if (r == 9) drive(1, 4'h9, 32'h1, vs);
      else if (r == 10) drive(1, {2'd3, 2'($urandom)}, d, vs);
      else drive(0, 4'h0, 32'h0, vs);
      tick("R1/R3/R4");
      if (i % 8 == 0) begin
        bit [3:0] ra = 4'($urandom);
        readChk("R2", ra, 0);
        readChk("R2", ra, 1);
      end
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule